// File: doc/BRIEF.md
# Serial-Link Latency Measurement Timer

This block times the gap between a marker leaving the transmit side of a serial transceiver datapath and the matching marker arriving on the receive side. It counts ticks of a chosen measurement clock. The clock input `clk` stands for the serial bit clock. A tick enable is derived from it in one of two ways:

- The high-speed source divides the bit rate by a factor set by the link rate mode. That clock can then be slowed further by a prescaler.
- The byte source runs at one twentieth of the bit rate.

No derived clock is built. Everything runs on `clk` with a per-cycle enable.

Software sets the rate mode, source and prescaler, then sends a start strobe with the transmit marker and a stop strobe with the receive marker. It then reads a raw tick count. Turning the count into time is left to software, which knows the selected tick frequency. The result is good to within one tick period. Each doubling of the prescaler doubles the range and halves the resolution.

Top module: `lnk_lat_timer`

## Requirements
- R1: After a synchronous active-low reset, `result` is 0, `done` is 0 and `ovf` is 0.
- R2: With `cfg_src`=0 and `cfg_div`=0, the tick period is 8, 4, 2 or 1 `clk` cycles for `cfg_rate` codes 0 (full), 1 (half), 2 (quarter) and 3 (eighth). If stop is sampled N cycles after start, `result` equals floor(N / period).
- R3: With `cfg_src`=1 (byte source), the tick period is 20 `clk` cycles whatever `cfg_rate` and `cfg_div` hold.
- R4: With `cfg_src`=0, `cfg_div` codes 0, 1, 2 and 3 multiply the rate-mode period by 1, 2, 4 and 8.
- R5: `done` is high for exactly one cycle, in the cycle after the edge where an armed measurement samples `stop`. `result` shows the new count in that same cycle.
- R6: A `stop` that arrives while no measurement is armed is ignored. `done` stays low and `result` does not change.
- R7: If the count reaches all-ones before `stop`, the measurement ends and `ovf` goes high. `result` becomes all-ones and `done` is not raised. A later `stop` is ignored.
- R8: `ovf` stays set until the next `start` and reads 0 in the cycle after that start.
- R9: A `start` during an armed measurement restarts it, with the count and the tick phase set back to zero.
- R10: A configuration write (`cfg_wr`) while idle takes effect for the next measurement. A write during a measurement is held: the running measurement keeps the old settings and the held settings apply once it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock (model time base) |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_rate | input | 2 | Rate mode: 0 full, 1 half, 2 quarter, 3 eighth |
| cfg_src | input | 1 | Tick source: 0 high-speed, 1 byte clock |
| cfg_div | input | 2 | Prescaler code: divide by 1, 2, 4, 8 |
| start | input | 1 | Transmit-marker strobe: clear and arm |
| stop | input | 1 | Receive-marker strobe: freeze count |
| result | output | CNT_W | Latched tick count |
| done | output | 1 | One-cycle pulse when a result is latched |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Timing of each result relative to its trigger:

- **`done` and `result`:** both are registered, so they appear one cycle after the rising edge that samples `stop`.
- **`ovf`:** it appears one cycle after the edge on which the count reaches all-ones, and clears one cycle after the edge that samples `start`.
- **Configuration writes:** a write made while idle is in force from the next edge. A write made during a measurement becomes active at the edge that ends the measurement.

The bench drives every strobe on a falling edge and holds it across exactly one rising edge. It samples on the falling edge that follows the edge the result is due on. It checks again one falling edge later to confirm that `done` has dropped.

// File: rtl/lnk_lat_pkg.sv
// Shared types and helpers for the latency measurement timer.
// Assumes the model clock is the serial bit clock; all periods are in its cycles.
package lnk_lat_pkg;

    localparam int PH_W     = 7;   // wide enough for the largest period (64)
    localparam int BYTE_DIV = 20;  // byte clock runs at bit rate / 20

    typedef enum logic [1:0] {
        RATE_FULL    = 2'd0,
        RATE_HALF    = 2'd1,
        RATE_QUARTER = 2'd2,
        RATE_EIGHTH  = 2'd3
    } rate_e;

    typedef struct packed {
        rate_e      rate;
        logic       src;   // 0 high-speed, 1 byte clock
        logic [1:0] div;   // prescaler exponent
    } lat_cfg_t;

    // Tick period in model clock cycles for a given configuration.
    function automatic logic [PH_W-1:0] period_of(lat_cfg_t c);
        logic [PH_W-1:0] base;
        if (c.src) begin
            return PH_W'(BYTE_DIV);
        end
        base = PH_W'(8) >> c.rate;
        return base << c.div;
    endfunction

endpackage

// File: rtl/lnk_lat_cfg.sv
// Configuration holding register.
// Writes while idle go straight to the active set; writes during a measurement
// are parked and promoted when the measurement ends (stop accepted or overflow).
// Assumes busy and fin come from the counter in the same clock domain.
module lnk_lat_cfg
    import lnk_lat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  lat_cfg_t wr_cfg,
    input  logic     busy,
    input  logic     fin,
    output lat_cfg_t active
);

    lat_cfg_t held;
    logic     held_v;

    // Update the active and parked configuration sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '{rate: RATE_FULL, src: 1'b0, div: 2'd0};
            held   <= '{rate: RATE_FULL, src: 1'b0, div: 2'd0};
            held_v <= 1'b0;
        end else if (!busy) begin
            if (wr) begin
                active <= wr_cfg;
            end
            held_v <= 1'b0;
        end else begin
            if (fin) begin
                if (wr) begin
                    active <= wr_cfg;
                end else if (held_v) begin
                    active <= held;
                end
                held_v <= 1'b0;
            end else if (wr) begin
                held   <= wr_cfg;
                held_v <= 1'b1;
            end
        end
    end

    // R10: settings must not move while a measurement stays armed
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(active));

endmodule

// File: rtl/lnk_lat_tick.sv
// Tick enable generator.
// Produces a one-cycle enable every period_of(cfg) cycles while armed, with
// phase zeroed by each start so the first tick lands a full period later.
module lnk_lat_tick
    import lnk_lat_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  lat_cfg_t cfg,
    input  logic     start,
    input  logic     busy,
    output logic     tick
);

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] period;
    logic            wrap;

    // Derive the period and the wrap point of the phase counter.
    always_comb begin
        period = period_of(cfg);
        wrap   = (phase == period - PH_W'(1));
        tick   = busy && !start && wrap;
    end

    // Advance the phase counter while armed; restart on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (start) begin
            phase <= '0;
        end else if (busy) begin
            phase <= wrap ? '0 : phase + PH_W'(1);
        end
    end

    // R2: phase never runs past the configured period while armed
    p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (phase < period));

    // R3: byte source ticks no faster than every 20 cycles
    p_byte_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg.src) |=> !tick);

endmodule

// File: rtl/lnk_lat_count.sv
// Measurement counter and result register.
// start clears and arms; ticks increment; stop latches count (including a tick
// on the same edge) and pulses done; reaching all-ones ends the run with a
// sticky overflow instead.
module lnk_lat_count #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             tick,
    output logic             busy,
    output logic             fin,
    output logic [CNT_W-1:0] result,
    output logic             done,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_MAX - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             hit_max;
    logic             stop_ok;

    // Next count and end-of-measurement decode.
    always_comb begin
        cnt_nxt = cnt + {{(CNT_W-1){1'b0}}, tick};
        hit_max = busy && !start && tick && (cnt == CNT_LAST);
        stop_ok = busy && !start && stop && !hit_max;
        fin     = hit_max || stop_ok;
    end

    // Run the measurement state, count, result and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            result <= '0;
            done   <= 1'b0;
            ovf    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
                ovf  <= 1'b0;
            end else if (hit_max) begin
                busy   <= 1'b0;
                cnt    <= CNT_MAX;
                result <= CNT_MAX;
                ovf    <= 1'b1;
            end else if (stop_ok) begin
                busy   <= 1'b0;
                result <= cnt_nxt;
                done   <= 1'b1;
            end else if (busy) begin
                cnt <= cnt_nxt;
            end
        end
    end

    // R5: done is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: done only follows a sampled stop
    p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(stop));

    // R8: overflow stays set until a start
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !start) |=> ovf);

    // R7: result moves only with done or a fresh overflow
    p_result_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> (done || $rose(ovf)));

endmodule

// File: rtl/lnk_lat_timer.sv
// Top level of the serial-link latency measurement timer.
// Wires configuration holding, tick generation and counting together.
// Assumes clk is the serial bit clock and all strobes are synchronous to it.
module lnk_lat_timer
    import lnk_lat_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_rate,
    input  logic             cfg_src,
    input  logic [1:0]       cfg_div,
    input  logic             start,
    input  logic             stop,
    output logic [CNT_W-1:0] result,
    output logic             done,
    output logic             ovf
);

    lat_cfg_t wr_cfg;
    lat_cfg_t act_cfg;
    logic     busy;
    logic     fin;
    logic     tick;

    // Pack the configuration inputs.
    always_comb begin
        wr_cfg.rate = rate_e'(cfg_rate);
        wr_cfg.src  = cfg_src;
        wr_cfg.div  = cfg_div;
    end

    lnk_lat_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wr_cfg (wr_cfg),
        .busy   (busy),
        .fin    (fin),
        .active (act_cfg)
    );

    lnk_lat_tick u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (act_cfg),
        .start (start),
        .busy  (busy),
        .tick  (tick)
    );

    lnk_lat_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .stop   (stop),
        .tick   (tick),
        .busy   (busy),
        .fin    (fin),
        .result (result),
        .done   (done),
        .ovf    (ovf)
    );

endmodule

// File: tb/tb_lnk_lat_timer.sv
`timescale 1ns/1ps
module tb_lnk_lat_timer;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [1:0]    cfg_rate = 2'd0;
    logic          cfg_src = 1'b0;
    logic [1:0]    cfg_div = 2'd0;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic [CW-1:0] result;
    logic          done;
    logic          ovf;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    lnk_lat_timer #(.CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rate(cfg_rate),
        .cfg_src(cfg_src), .cfg_div(cfg_div), .start(start), .stop(stop),
        .result(result), .done(done), .ovf(ovf)
    );

    // rate[22:21] src[20] div[19:18] N[17:8] expected[7:0]
    localparam int NV = 9;
    localparam logic [22:0] VEC [NV] = '{
        {2'd0, 1'b0, 2'd0, 10'd100, 8'd12},  // R2 full, P8
        {2'd1, 1'b0, 2'd0, 10'd50,  8'd12},  // R2 half, P4
        {2'd2, 1'b0, 2'd0, 10'd37,  8'd18},  // R2 quarter, P2
        {2'd3, 1'b0, 2'd0, 10'd45,  8'd45},  // R2 eighth, P1
        {2'd0, 1'b0, 2'd1, 10'd200, 8'd12},  // R4 P16
        {2'd1, 1'b0, 2'd3, 10'd100, 8'd3},   // R4 P32
        {2'd0, 1'b1, 2'd3, 10'd100, 8'd5},   // R3 byte, P20
        {2'd3, 1'b0, 2'd2, 10'd7,   8'd1},   // R4 P4
        {2'd2, 1'b0, 2'd3, 10'd15,  8'd0}    // R4 P16, short
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] r, input logic s, input logic [1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_rate = r; cfg_src = s; cfg_div = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
    endtask

    // Start, wait so stop is sampled n cycles after start, optionally write
    // new settings mid-run; returns with done cycle sampled.
    task automatic measure(input int n, input logic mid_wr,
                           input logic [1:0] r, input logic [1:0] d,
                           output int got, output logic got_done);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n - 1; i++) begin
            if (mid_wr && i == 2) begin
                cfg_wr = 1'b1; cfg_rate = r; cfg_src = 1'b0; cfg_div = d;
            end else begin
                cfg_wr = 1'b0;
            end
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        got = int'(result);
        got_done = done;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int   got;
        logic gd;
        int   seen_done;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 result", int'(result), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 ovf", int'(ovf), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 stop with nothing armed
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R6 done", int'(done), 0);
        chk("R6 result", int'(result), 0);

        // Table walk: R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            set_cfg(VEC[v][22:21], VEC[v][20], VEC[v][19:18]);
            measure(int'(VEC[v][17:8]), 1'b0, 2'd0, 2'd0, got, gd);
            chk("R2/R3/R4 result", got, int'(VEC[v][7:0]));
            chk("R5 done high", int'(gd), 1);
            @(negedge clk);
            chk("R5 done drops", int'(done), 0);
        end

        // R6 stray stop after a completed run leaves result alone
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R6 done after run", int'(done), 0);
        chk("R6 result after run", int'(result), 0);

        // R10 held write: run with P1, write P8 mid-run
        set_cfg(2'd3, 1'b0, 2'd0);
        measure(40, 1'b1, 2'd0, 2'd0, got, gd);
        chk("R10 old cfg kept", got, 40);
        @(negedge clk);
        measure(40, 1'b0, 2'd0, 2'd0, got, gd);
        chk("R10 held cfg applied", got, 5);

        // R9 restart mid-run
        set_cfg(2'd3, 1'b0, 2'd0);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        measure(30, 1'b0, 2'd0, 2'd0, got, gd);
        chk("R9 restart result", got, 30);

        // R7 overflow with P1
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen_done = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (done) seen_done++;
        end
        chk("R7 ovf set", int'(ovf), 1);
        chk("R7 result all-ones", int'(result), 255);
        chk("R7 no done", seen_done, 0);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R7 late stop ignored", int'(done), 0);
        @(negedge clk);
        chk("R8 ovf still set", int'(ovf), 1);

        // R8 cleared by start
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8 ovf cleared", int'(ovf), 0);
        repeat (4) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R5 short run", int'(result), 5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule